// File: doc/BRIEF.md
# Serial Bus Control and Detection Register

This block is the 8-bit control and status register that sits beside the shift logic of a two-wire serial bus port. Software writes it either as a whole byte or one bit at a time. Two self-clearing trigger bits act directly on the serial-output latch. One trigger drives the latch high to release the bus. The other drives it low to issue a command. A third trigger arms a one-shot acknowledge. That acknowledge is driven on the next falling edge of the serial clock after the write, and the trigger is consumed when this happens.

The register also holds three sticky status flags: bus release seen, command seen and acknowledge seen. External detectors set them with single-cycle pulses. Each flag has its own list of clear events. One of these is an address mismatch during address reception, and it only counts in wake-up mode. When a set event and a clear event for the same flag fall in the same cycle, the clear wins. Dropping the interface enable clears all flags and triggers, and it removes the acknowledge drive. The serial clock is asynchronous to the system clock. It is brought in through a synchronizer chain, and its edges are detected in the system clock domain.

Top module: `sbus_ctl_reg`

## Requirements
- R1: After reset the read data is 8'h00, `so_latch_o` is 1 and `ack_drive_o` is 0.
- R2: Read data bit layout: bit 7 hold-enable (R/W), bit 6 ack-seen flag, bit 5 auto-ack enable (R/W), bit 4 reads 0, bit 3 command-seen flag, bit 2 release-seen flag, bits 1 and 0 read 0. Writes to bits 6, 3 and 2 are ignored.
- R3: A write of 1 to bit 0 (release trigger) while enabled makes `so_latch_o` 1 from the next cycle. Bit 0 never reads back as 1.
- R4: A write of 1 to bit 1 (command trigger) while enabled makes `so_latch_o` 0 from the next cycle. If bits 0 and 1 are both written 1, the latch goes to 0. Triggers written while `en_i` is 0 leave the latch unchanged.
- R5: The release-seen flag sets on `rel_det_i`. It clears on `xfer_start_i`, on `en_i` = 0, or on `addr_rx_i` with `addr_match_i` = 0 while `wake_mode_i` = 1. A mismatch with `wake_mode_i` = 0 leaves the flag set.
- R6: The command-seen flag sets on `cmd_det_i`. It clears on `xfer_start_i`, on `en_i` = 0, or on `rel_det_i`.
- R7: The ack-seen flag sets on `ack_det_i`. It clears on `xfer_start_i` or on `en_i` = 0.
- R8: A clear event and a set event for the same flag in the same cycle leave the flag at 0.
- R9: After a write of 1 to bit 4, a falling edge of `sck_i` raises `ack_drive_o` on the third clock edge after the fall. It falls on the third edge after the next rise. The armed acknowledge fires only once.
- R10: `xfer_start_i` or `en_i` = 0 disarms a pending acknowledge. `en_i` = 0 forces `ack_drive_o` to 0 on the next edge.
- R11: A single-bit write (`wr_bit_i`) updates only bit `bit_idx_i` with `bit_val_i`. When `wr_byte_i` is high in the same cycle, the byte write is used instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Serial interface enable |
| wr_byte_i | input | 1 | Full-byte write strobe |
| wr_data_i | input | 8 | Byte write data |
| wr_bit_i | input | 1 | Single-bit write strobe |
| bit_idx_i | input | 3 | Bit index for single-bit write |
| bit_val_i | input | 1 | Value for single-bit write |
| rd_data_o | output | 8 | Register read data |
| xfer_start_i | input | 1 | Transfer-start strobe |
| rel_det_i | input | 1 | Bus-release detected pulse |
| cmd_det_i | input | 1 | Command detected pulse |
| ack_det_i | input | 1 | Acknowledge detected pulse |
| addr_rx_i | input | 1 | Address reception complete pulse |
| addr_match_i | input | 1 | Received address matched |
| wake_mode_i | input | 1 | Wake-up mode active |
| sck_i | input | 1 | Serial clock, asynchronous |
| so_latch_o | output | 1 | Serial-output latch value |
| ack_drive_o | output | 1 | Acknowledge drive |

## Verification
The contested cycles are a detector pulse that meets one of its flag's clear events. Examples are `rel_det_i` together with `xfer_start_i`, a mismatch in wake-up mode, or `cmd_det_i` together with `rel_det_i`. A byte write that fires both latch triggers at once is contested in the same way. Directed steps force each of these pairs into a single cycle. Seeded random stimulus then keeps raising the detector pulses, clear strobes and writes together. A bench model predicts the read data and the latch one edge later, with clear over set and command over release. The acknowledge path is judged by counting clock edges after each serial-clock transition.

// File: rtl/sbus_ctl_pkg.sv
package sbus_ctl_pkg;

   localparam int unsigned REG_W = 8;

   // bit positions; the read layout and trigger semantics depend on them
   localparam int unsigned B_REL_TRIG = 0;
   localparam int unsigned B_CMD_TRIG = 1;
   localparam int unsigned B_REL_FLAG = 2;
   localparam int unsigned B_CMD_FLAG = 3;
   localparam int unsigned B_ACK_TRIG = 4;
   localparam int unsigned B_ACK_AUTO = 5;
   localparam int unsigned B_ACK_FLAG = 6;
   localparam int unsigned B_HOLD     = 7;

   localparam int unsigned N_FLAGS = 3;
   localparam int unsigned F_REL = 0;
   localparam int unsigned F_CMD = 1;
   localparam int unsigned F_ACK = 2;

   typedef struct packed {
      logic set;
      logic clr;
   } flag_evt_t;

   typedef enum logic [1:0] {
      SO_KEEP = 2'd0,
      SO_SET  = 2'd1,
      SO_CLR  = 2'd2
   } so_op_t;

endpackage

// File: rtl/sbus_wr_decode.sv
module sbus_wr_decode #(
   parameter int unsigned W  = 8,
   localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          wr_byte_i,
   input  logic [W-1:0]  wr_data_i,
   input  logic          wr_bit_i,
   input  logic [IW-1:0] bit_idx_i,
   input  logic          bit_val_i,
   output logic [W-1:0]  we_o,
   output logic [W-1:0]  wd_o
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic hit;
      assign hit   = wr_bit_i && (bit_idx_i == IW'(i));
      // byte access wins over a concurrent single-bit access
      assign we_o[i] = wr_byte_i | hit;
      assign wd_o[i] = wr_byte_i ? wr_data_i[i] : bit_val_i;
   end

endmodule

// File: rtl/sbus_sck_edge.sv
module sbus_sck_edge #(
   parameter int unsigned STAGES = 2,
   parameter bit          IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   output logic fall_o,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sbus_sck_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= IDLE;
      else        chain[0] <= sck_i;
   end

   for (genvar k = 1; k <= STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[k] <= IDLE;
         else        chain[k] <= chain[k-1];
      end
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   assign fall_o =  chain[STAGES] & ~chain[STAGES-1];
   assign rise_o = ~chain[STAGES] &  chain[STAGES-1];

endmodule

// File: rtl/sbus_det_flag.sv
module sbus_det_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end

endmodule

// File: rtl/sbus_trig_ctl.sv
module sbus_trig_ctl
   import sbus_ctl_pkg::*;
#(
   parameter bit SO_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic rel_req_i,
   input  logic cmd_req_i,
   input  logic ack_req_i,
   input  logic xfer_start_i,
   input  logic sck_fall_i,
   input  logic sck_rise_i,
   output logic so_latch_o,
   output logic ack_drive_o
);

   so_op_t so_op;
   logic   ack_pend;

   always_comb begin
      so_op = SO_KEEP;
      if (en_i) begin
         if (cmd_req_i)      so_op = SO_CLR;
         else if (rel_req_i) so_op = SO_SET;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) so_latch_o <= SO_RST;
      else begin
         case (so_op)
            SO_SET:  so_latch_o <= 1'b1;
            SO_CLR:  so_latch_o <= 1'b0;
            default: so_latch_o <= so_latch_o;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ack_pend <= 1'b0;
      else if (!en_i || xfer_start_i) ack_pend <= 1'b0;
      else if (ack_req_i)            ack_pend <= 1'b1;
      else if (sck_fall_i)           ack_pend <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        ack_drive_o <= 1'b0;
      else if (!en_i)                                    ack_drive_o <= 1'b0;
      else if (sck_fall_i && ack_pend && !xfer_start_i)  ack_drive_o <= 1'b1;
      else if (sck_rise_i)                               ack_drive_o <= 1'b0;
   end

endmodule

// File: rtl/sbus_ctl_reg.sv
module sbus_ctl_reg
   import sbus_ctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SO_RST      = 1'b1,
   parameter bit          SCK_IDLE    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       wr_byte_i,
   input  logic [7:0] wr_data_i,
   input  logic       wr_bit_i,
   input  logic [2:0] bit_idx_i,
   input  logic       bit_val_i,
   output logic [7:0] rd_data_o,
   input  logic       xfer_start_i,
   input  logic       rel_det_i,
   input  logic       cmd_det_i,
   input  logic       ack_det_i,
   input  logic       addr_rx_i,
   input  logic       addr_match_i,
   input  logic       wake_mode_i,
   input  logic       sck_i,
   output logic       so_latch_o,
   output logic       ack_drive_o
);

   if (REG_W != 8) begin : g_bad_width
      $error("sbus_ctl_reg: register width must be 8");
   end

   logic [REG_W-1:0] we, wd;
   logic             sck_fall, sck_rise;
   logic             hold_q, auto_q;
   flag_evt_t        evt [N_FLAGS];
   logic [N_FLAGS-1:0] flag_q;
   logic             unused_ro_wr;

   sbus_wr_decode #(.W(REG_W)) u_dec (
      .wr_byte_i (wr_byte_i),
      .wr_data_i (wr_data_i),
      .wr_bit_i  (wr_bit_i),
      .bit_idx_i (bit_idx_i),
      .bit_val_i (bit_val_i),
      .we_o      (we),
      .wd_o      (wd)
   );

   assign unused_ro_wr = ^{we[B_REL_FLAG], wd[B_REL_FLAG], we[B_CMD_FLAG],
                           wd[B_CMD_FLAG], we[B_ACK_FLAG], wd[B_ACK_FLAG]};

   sbus_sck_edge #(.STAGES(SYNC_STAGES), .IDLE(SCK_IDLE)) u_sck (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_i  (sck_i),
      .fall_o (sck_fall),
      .rise_o (sck_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         auto_q <= 1'b0;
      end else begin
         if (we[B_HOLD])     hold_q <= wd[B_HOLD];
         if (we[B_ACK_AUTO]) auto_q <= wd[B_ACK_AUTO];
      end
   end

   logic mismatch_clr;
   assign mismatch_clr = addr_rx_i & ~addr_match_i & wake_mode_i;

   assign evt[F_REL].set = rel_det_i;
   assign evt[F_REL].clr = xfer_start_i | ~en_i | mismatch_clr;
   assign evt[F_CMD].set = cmd_det_i;
   assign evt[F_CMD].clr = xfer_start_i | ~en_i | rel_det_i;
   assign evt[F_ACK].set = ack_det_i;
   assign evt[F_ACK].clr = xfer_start_i | ~en_i;

   for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
      sbus_det_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt[f].set),
         .clr_i (evt[f].clr),
         .q_o   (flag_q[f])
      );
   end

   sbus_trig_ctl #(.SO_RST(SO_RST)) u_trig (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .rel_req_i    (we[B_REL_TRIG] & wd[B_REL_TRIG]),
      .cmd_req_i    (we[B_CMD_TRIG] & wd[B_CMD_TRIG]),
      .ack_req_i    (we[B_ACK_TRIG] & wd[B_ACK_TRIG]),
      .xfer_start_i (xfer_start_i),
      .sck_fall_i   (sck_fall),
      .sck_rise_i   (sck_rise),
      .so_latch_o   (so_latch_o),
      .ack_drive_o  (ack_drive_o)
   );

   always_comb begin
      rd_data_o             = '0;
      rd_data_o[B_HOLD]     = hold_q;
      rd_data_o[B_ACK_FLAG] = flag_q[F_ACK];
      rd_data_o[B_ACK_AUTO] = auto_q;
      rd_data_o[B_CMD_FLAG] = flag_q[F_CMD];
      rd_data_o[B_REL_FLAG] = flag_q[F_REL];
   end

endmodule

// File: rtl/sbus_ctl_reg_chk.sv
module sbus_ctl_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       wr_byte_i,
   input logic [7:0] wr_data_i,
   input logic       wr_bit_i,
   input logic       xfer_start_i,
   input logic       rel_det_i,
   input logic       cmd_det_i,
   input logic       addr_rx_i,
   input logic       addr_match_i,
   input logic       wake_mode_i,
   input logic [7:0] rd_data_o,
   input logic       so_latch_o,
   input logic       ack_drive_o
);

   p_trig_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[4] == 1'b0) && (rd_data_o[1:0] == 2'b00));

   p_rel_trig_sets_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && wr_byte_i && wr_data_i[0] && !wr_data_i[1]) |=> so_latch_o);

   p_cmd_trig_clears_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && wr_byte_i && wr_data_i[1]) |=> !so_latch_o);

   p_latch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_byte_i && !wr_bit_i) |=> $stable(so_latch_o));

   p_rel_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start_i || !en_i || (addr_rx_i && !addr_match_i && wake_mode_i))
      |=> !rd_data_o[2]);

   p_rel_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_det_i && en_i && !xfer_start_i && !(addr_rx_i && !addr_match_i && wake_mode_i))
      |=> rd_data_o[2]);

   p_cmd_clear_on_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rel_det_i |=> !rd_data_o[3]);

   p_cmd_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_det_i && en_i && !xfer_start_i && !rel_det_i) |=> rd_data_o[3]);

   p_ack_off_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !ack_drive_o);

endmodule

bind sbus_ctl_reg sbus_ctl_reg_chk u_chk (.*);

// File: tb/tb_sbus_ctl_reg.sv
module tb_sbus_ctl_reg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic       wr_byte_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       wr_bit_i = 1'b0;
   logic [2:0] bit_idx_i = '0;
   logic       bit_val_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       xfer_start_i = 1'b0;
   logic       rel_det_i = 1'b0;
   logic       cmd_det_i = 1'b0;
   logic       ack_det_i = 1'b0;
   logic       addr_rx_i = 1'b0;
   logic       addr_match_i = 1'b0;
   logic       wake_mode_i = 1'b0;
   logic       sck_i = 1'b1;
   logic       so_latch_o;
   logic       ack_drive_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // model state: [5] hold, [4] ack flag, [3] auto, [2] cmd flag, [1] rel flag, [0] latch
   logic [5:0] m;

   always #10 clk = ~clk;

   sbus_ctl_reg dut (.*);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<=100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic logic [7:0] f_rd(input logic [5:0] s);
      return {s[5], s[4], s[3], 1'b0, s[2], s[1], 2'b00};
   endfunction

   function automatic logic [5:0] f_next(input logic [5:0] s);
      logic [7:0] we, wd;
      logic [5:0] n;
      we = '0;
      wd = '0;
      for (int i = 0; i < 8; i++) begin
         if (wr_byte_i) begin
            we[i] = 1'b1;
            wd[i] = wr_data_i[i];
         end else if (wr_bit_i && bit_idx_i == 3'(i)) begin
            we[i] = 1'b1;
            wd[i] = bit_val_i;
         end
      end
      n = s;
      if (we[7]) n[5] = wd[7];
      if (we[5]) n[3] = wd[5];
      if (en_i) begin
         if (we[1] && wd[1])      n[0] = 1'b0;
         else if (we[0] && wd[0]) n[0] = 1'b1;
      end
      if (xfer_start_i || !en_i || (addr_rx_i && !addr_match_i && wake_mode_i)) n[1] = 1'b0;
      else if (rel_det_i) n[1] = 1'b1;
      if (xfer_start_i || !en_i || rel_det_i) n[2] = 1'b0;
      else if (cmd_det_i) n[2] = 1'b1;
      if (xfer_start_i || !en_i) n[4] = 1'b0;
      else if (ack_det_i) n[4] = 1'b1;
      return n;
   endfunction

   task automatic clear_pulses();
      wr_byte_i = 1'b0; wr_bit_i = 1'b0; xfer_start_i = 1'b0;
      rel_det_i = 1'b0; cmd_det_i = 1'b0; ack_det_i = 1'b0; addr_rx_i = 1'b0;
   endtask

   // one clock with the current inputs; compare register and latch afterwards
   task automatic step(input string tag);
      m = f_next(m);
      @(posedge clk);
      @(negedge clk);
      clear_pulses();
      checks++;
      if (rd_data_o !== f_rd(m) || so_latch_o !== m[0]) begin
         errors++;
         $display("FAIL %s: rd=%02h so=%b expected rd=%02h so=%b", tag,
                  rd_data_o, so_latch_o, f_rd(m), m[0]);
      end
   endtask

   task automatic chk_ack(input string tag, input logic exp);
      checks++;
      if (ack_drive_o !== exp) begin
         errors++;
         $display("FAIL %s: ack_drive=%b expected %b", tag, ack_drive_o, exp);
      end
   endtask

   task automatic steps(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      logic [31:0] seed;
      seed = 32'd1234;
      void'($urandom(seed));
      m = 6'b000001;
      repeat (3) @(negedge clk);
      // R1 reset values
      checks++;
      if (rd_data_o !== 8'h00 || so_latch_o !== 1'b1 || ack_drive_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: rd=%02h so=%b ack=%b expected rd=00 so=1 ack=0",
                  rd_data_o, so_latch_o, ack_drive_o);
      end
      rst_n = 1'b1;
      en_i  = 1'b1;
      step("R1");

      // R2 writable bits and ignored read-only bits
      wr_byte_i = 1'b1; wr_data_i = 8'hEC; step("R2");
      wr_byte_i = 1'b1; wr_data_i = 8'h00; step("R2");

      // R4 command trigger, then R3 release trigger
      wr_byte_i = 1'b1; wr_data_i = 8'h02; step("R4");
      wr_byte_i = 1'b1; wr_data_i = 8'h01; step("R3");
      wr_byte_i = 1'b1; wr_data_i = 8'h03; step("R4 both triggers");
      en_i = 1'b0; wr_byte_i = 1'b1; wr_data_i = 8'h01; step("R4 disabled");
      en_i = 1'b1; step("R4");

      // R5 release flag and mismatch handling
      rel_det_i = 1'b1; step("R5 set");
      addr_rx_i = 1'b1; addr_match_i = 1'b0; wake_mode_i = 1'b0; step("R5 no wake");
      addr_rx_i = 1'b1; wake_mode_i = 1'b1; step("R5 mismatch wake");
      wake_mode_i = 1'b0;

      // R6 command flag
      cmd_det_i = 1'b1; step("R6 set");
      rel_det_i = 1'b1; step("R6 cleared by release");
      cmd_det_i = 1'b1; step("R6 set");
      xfer_start_i = 1'b1; step("R6 xfer clear");

      // R7 ack flag
      ack_det_i = 1'b1; step("R7 set");
      en_i = 1'b0; step("R7 disable clear");
      en_i = 1'b1;

      // R8 set and clear together
      rel_det_i = 1'b1; xfer_start_i = 1'b1; step("R8 rel");
      cmd_det_i = 1'b1; rel_det_i = 1'b1; step("R8 cmd");
      ack_det_i = 1'b1; xfer_start_i = 1'b1; step("R8 ack");

      // R11 single-bit writes
      wr_bit_i = 1'b1; bit_idx_i = 3'd7; bit_val_i = 1'b1; step("R11");
      wr_bit_i = 1'b1; bit_idx_i = 3'd1; bit_val_i = 1'b1; step("R11 cmd trig");
      wr_bit_i = 1'b1; bit_idx_i = 3'd5; bit_val_i = 1'b1;
      wr_byte_i = 1'b1; wr_data_i = 8'h01; step("R11 byte wins");

      // R9 acknowledge timing
      wr_byte_i = 1'b1; wr_data_i = 8'h10; step("R9");
      sck_i = 1'b0; steps(2, "R9"); chk_ack("R9 before", 1'b0);
      step("R9"); chk_ack("R9 rise", 1'b1);
      sck_i = 1'b1; steps(2, "R9"); chk_ack("R9 hold", 1'b1);
      step("R9"); chk_ack("R9 drop", 1'b0);
      sck_i = 1'b0; steps(3, "R9"); chk_ack("R9 one shot", 1'b0);
      sck_i = 1'b1; steps(3, "R9");

      // R10 disarm by transfer start and by disable
      wr_byte_i = 1'b1; wr_data_i = 8'h10; step("R10");
      xfer_start_i = 1'b1; step("R10");
      sck_i = 1'b0; steps(3, "R10"); chk_ack("R10 xfer disarm", 1'b0);
      sck_i = 1'b1; steps(3, "R10");
      wr_byte_i = 1'b1; wr_data_i = 8'h10; step("R10");
      en_i = 1'b0; step("R10"); en_i = 1'b1;
      sck_i = 1'b0; steps(3, "R10"); chk_ack("R10 disable disarm", 1'b0);
      sck_i = 1'b1; steps(3, "R10");
      wr_byte_i = 1'b1; wr_data_i = 8'h10; step("R10");
      sck_i = 1'b0; steps(3, "R10"); chk_ack("R10 armed", 1'b1);
      en_i = 1'b0; step("R10"); chk_ack("R10 forced off", 1'b0);
      en_i = 1'b1; sck_i = 1'b1; steps(3, "R10");

      // random mix, acknowledge trigger masked out
      for (int k = 0; k < 600; k++) begin
         en_i         = ($urandom_range(0, 7) != 0);
         wr_byte_i    = ($urandom_range(0, 3) == 0);
         wr_data_i    = 8'($urandom()) & 8'hEF;
         wr_bit_i     = ($urandom_range(0, 3) == 0);
         bit_idx_i    = 3'($urandom_range(0, 7));
         if (bit_idx_i == 3'd4) bit_idx_i = 3'd5;
         bit_val_i    = 1'($urandom());
         xfer_start_i = ($urandom_range(0, 7) == 0);
         rel_det_i    = ($urandom_range(0, 3) == 0);
         cmd_det_i    = ($urandom_range(0, 2) == 0);
         ack_det_i    = ($urandom_range(0, 3) == 0);
         addr_rx_i    = ($urandom_range(0, 3) == 0);
         addr_match_i = 1'($urandom());
         wake_mode_i  = 1'($urandom());
         step("R2 R3 R4 R5 R6 R7 R8 R11 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule